// File: doc/BRIEF.md
# Double-Buffered Serial Register Port

This block is the control port of a larger chip. A host addresses a bank of configuration registers through four signals: an active-low select, a serial clock, and a data line that can also be turned around for reads. It can also use a separate data-out line. All serial inputs are brought into the system clock domain and their edges are detected there. This means the serial clock may idle either low or high between transactions.

Each transaction begins with an 8-bit instruction that carries a read flag and a 5-bit register address. After it comes the data word, whose length depends on the address. Writes land in a buffer copy of the register. The copy driving the rest of the chip changes only when a qualified update strobe arrives. Two bits of register 0 choose the shift order and the read-out wiring. A separate abort input clears a half-finished transaction without touching any register.

Top module: `sreg_port`

## Requirements
- R1: After reset, every buffer and active register is zero, `sdo` and `sdio_oe` are low, shifting is MSB first and reads use the separate `sdo` line.
- R2: Instruction bit 7 set means read and clear means write, and bits 4:0 are the address. Even addresses below NREGS (8) hold 32 bits, sent as 4 bytes. Odd addresses below NREGS hold 16 bits, sent as 2 bytes; the upper half of the register reads as zero. Addresses at or above NREGS take one dummy byte: the write is dropped and the read returns zero.
- R3: Input bits are sampled on rising `sclk` edges, and a transaction works the same whether `sclk` idles low or high.
- R4: A serial write changes only the buffer register. `act_flat` holds register i at bits [32*i+31:32*i] and changes only on a qualified update.
- R5: An update fires once per pulse, when `upd` has been high on at least two consecutive clock cycles. It then copies every buffer register into its active register. A one-cycle pulse is ignored.
- R6: Active register 0 bit 0 selects LSB-first order when set and MSB-first order when clear. The selected order applies to both the instruction and the whole data word.
- R7: A read returns the buffer register. The first data bit is launched on the first falling `sclk` edge after the eighth instruction bit, and each later bit on each later falling edge.
- R8: Active register 0 bit 1 selects the read wiring. When it is clear, read data goes out on `sdo` and `sdio_oe` stays low. When it is set, read data goes out on `sdio_out` with `sdio_oe` high during the data phase, and `sdo` stays low.
- R9: Raising `cs_n` before the last data bit discards the partial word. Bits that follow a complete word are ignored until `cs_n` goes high.
- R10: Holding `io_rst` high aborts the transaction in progress and leaves all registers intact. If `cs_n` stays low after release, the next bits form a new instruction.
- R11: `sdio_oe` and `sdo` are low whenever the port is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rst | input | 1 | Transaction abort, active high |
| upd | input | 1 | Buffer-to-active update strobe |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdio_in | input | 1 | Serial data input |
| sdio_out | output | 1 | Read data on the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo | output | 1 | Read data on the separate line |
| act_flat | output | NREGS*DW | All active registers, concatenated |

## Verification
The checker watches several properties on every cycle:
- the data outputs stay quiet while the port is deselected;
- the active registers hold still unless an update fires;
- an update fires only after the strobe has been high on the previous cycle;
- writes never occur while the port is deselected or just after an abort.

The bench's scenarios show the other behaviours. These are bit order, word lengths per address, partial-word discard, ignored trailing bits, a fresh instruction after abort, and both read wirings. For bit order, a register written LSB first must appear correctly at `act_flat`.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int INSTR_BITS = 8;
    localparam int ADDR_W     = 5;
    localparam int RD_FLAG    = 7;
    localparam int CTRL_LSB   = 0;
    localparam int CTRL_WIRE2 = 1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INSTR = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_DONE  = 3'd4
    } sp_state_e;

    // byte count of the word that follows an instruction for address a
    function automatic logic [2:0] reg_bytes(input logic [ADDR_W-1:0] a, input int nregs);
        if ({1'b0, a} >= (ADDR_W+1)'(nregs)) return 3'd1;
        else if (a[0])                       return 3'd2;
        else                                 return 3'd4;
    endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sreg_engine.sv
module sreg_engine
    import sreg_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              abort,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              lsb_first,
    input  logic [DW-1:0]     rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              dout,
    output logic              out_en
);
    localparam int PW = $clog2(DW);
    localparam int CW = PW + 1;

    typedef struct packed {
        sp_state_e         st;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     nbits;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic [DW-1:0]     word;
        logic              dout;
        logic              oe;
        logic              sclk_p;
    } eng_t;

    eng_t q, d;
    logic rise, fall;
    logic [PW-1:0] pos;
    logic [INSTR_BITS-1:0] ib;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        rd_addr = q.addr;
        ib      = '0;
        rise    = sclk_s & ~q.sclk_p;
        fall    = ~sclk_s & q.sclk_p;
        pos     = lsb_first ? q.cnt[PW-1:0] : PW'(q.nbits - CW'(1) - q.cnt);
        d.sclk_p = sclk_s;

        if (abort || !cs_act) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.dout = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.st    = ST_INSTR;
                    d.cnt   = '0;
                    d.nbits = CW'(INSTR_BITS);
                    d.word  = '0;
                    d.rd    = 1'b0;
                end
                ST_INSTR: begin
                    if (rise) begin
                        d.word[pos] = din_s;
                        if (q.cnt == CW'(INSTR_BITS - 1)) begin
                            ib      = d.word[INSTR_BITS-1:0];
                            d.addr  = ib[ADDR_W-1:0];
                            d.rd    = ib[RD_FLAG];
                            d.nbits = CW'(reg_bytes(ib[ADDR_W-1:0], NREGS)) << 3;
                            d.cnt   = '0;
                            rd_addr = ib[ADDR_W-1:0];
                            if (ib[RD_FLAG]) begin
                                d.word = rd_data;
                                d.st   = ST_RDATA;
                            end else begin
                                d.word = '0;
                                d.st   = ST_WDATA;
                            end
                        end else begin
                            d.cnt = q.cnt + CW'(1);
                        end
                    end
                end
                ST_WDATA: begin
                    if (rise) begin
                        d.word[pos] = din_s;
                        if (q.cnt == q.nbits - CW'(1)) begin
                            wr_en = 1'b1;
                            d.st  = ST_DONE;
                        end else begin
                            d.cnt = q.cnt + CW'(1);
                        end
                    end
                end
                ST_RDATA: begin
                    if (fall) begin
                        d.dout = q.word[pos];
                        d.oe   = 1'b1;
                        if (q.cnt == q.nbits - CW'(1)) d.st = ST_DONE;
                        else                           d.cnt = q.cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, nbits: '0, addr: '0, rd: 1'b0,
                   word: '0, dout: 1'b0, oe: 1'b0, sclk_p: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wr_addr = q.addr;
    assign wr_data = d.word;
    assign dout    = q.dout;
    assign out_en  = q.oe;
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int NREGS   = 8,
    parameter int DW      = 32,
    parameter int UPD_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              upd_s,
    output logic              upd_fire,
    output logic              ctrl_lsb,
    output logic              ctrl_wire2,
    output logic [NREGS*DW-1:0] act_flat
);
    localparam int AIW = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int UCW = $clog2(UPD_MIN + 1);
    localparam logic [DW-1:0] HALF_MASK = {{(DW/2){1'b0}}, {(DW - DW/2){1'b1}}};

    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] bufr;
        logic [NREGS-1:0][DW-1:0] act;
        logic [UCW-1:0]           ucnt;
    } bank_t;

    bank_t q, d;
    logic wr_hit, rd_hit;

    assign wr_hit   = ({1'b0, wr_addr} < (ADDR_W+1)'(NREGS));
    assign rd_hit   = ({1'b0, rd_addr} < (ADDR_W+1)'(NREGS));
    assign upd_fire = upd_s && (q.ucnt == UCW'(UPD_MIN - 1));

    always_comb begin
        d = q;
        if (!upd_s)                        d.ucnt = '0;
        else if (q.ucnt < UCW'(UPD_MIN))   d.ucnt = q.ucnt + UCW'(1);

        if (upd_fire) d.act = q.bufr;

        if (wr_en && wr_hit) begin
            d.bufr[wr_addr[AIW-1:0]] = wr_addr[0] ? (wr_data & HALF_MASK) : wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data    = rd_hit ? q.bufr[rd_addr[AIW-1:0]] : '0;
    assign ctrl_lsb   = q.act[0][CTRL_LSB];
    assign ctrl_wire2 = q.act[0][CTRL_WIRE2];
    assign act_flat   = q.act;
endmodule

// File: rtl/sreg_port.sv
module sreg_port
    import sreg_pkg::*;
#(
    parameter int NREGS       = 8,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2,
    parameter int UPD_MIN     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_rst,
    input  logic                upd,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                sdio_in,
    output logic                sdio_out,
    output logic                sdio_oe,
    output logic                sdo,
    output logic [NREGS*DW-1:0] act_flat
);
    logic [4:0] raw, synced;
    logic io_rst_s, upd_s, cs_s, sclk_s, din_s, cs_act;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic wr_en, upd_fire, ctrl_lsb, ctrl_wire2, eng_dout, eng_oe;

    assign raw = {io_rst, upd, cs_n, sclk, sdio_in};

    sreg_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00100)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(synced)
    );

    assign {io_rst_s, upd_s, cs_s, sclk_s, din_s} = synced;
    assign cs_act = ~cs_s;

    sreg_engine #(.NREGS(NREGS), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .abort(io_rst_s),
        .sclk_s(sclk_s), .din_s(din_s), .lsb_first(ctrl_lsb),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .dout(eng_dout), .out_en(eng_oe)
    );

    sreg_bank #(.NREGS(NREGS), .DW(DW), .UPD_MIN(UPD_MIN)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .upd_s(upd_s), .upd_fire(upd_fire), .ctrl_lsb(ctrl_lsb),
        .ctrl_wire2(ctrl_wire2), .act_flat(act_flat)
    );

    assign sdo      = eng_oe & ~ctrl_wire2 & eng_dout;
    assign sdio_oe  = eng_oe & ctrl_wire2;
    assign sdio_out = eng_oe & ctrl_wire2 & eng_dout;
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
    parameter int W = 256
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_act,
    input logic         io_rst_s,
    input logic         upd_s,
    input logic         upd_fire,
    input logic         wr_en,
    input logic         sdio_oe,
    input logic         sdo,
    input logic [W-1:0] act_flat
);
    p_quiet_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!sdio_oe && !sdo));

    p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> $stable(act_flat));

    p_update_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |-> $past(upd_s));

    p_abort_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        io_rst_s |=> (!wr_en && !sdio_oe));

    p_write_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cs_act);
endmodule

bind sreg_port sreg_port_chk #(.W(NREGS*DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .io_rst_s(io_rst_s),
    .upd_s(upd_s), .upd_fire(upd_fire), .wr_en(wr_en),
    .sdio_oe(sdio_oe), .sdo(sdo), .act_flat(act_flat)
);

// File: tb/sim_sreg_port.sv
module sim_sreg_port;
    localparam int NREGS = 8;
    localparam int DW    = 32;
    localparam int NV    = 6;

    logic clk = 1'b0, rst_n = 1'b0, io_rst = 1'b0, upd = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo;
    logic [NREGS*DW-1:0] act_flat;

    int checks = 0, errors = 0, line_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sreg_port #(.NREGS(NREGS), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .io_rst(io_rst), .upd(upd), .cs_n(cs_n),
        .sclk(sclk), .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdo(sdo), .act_flat(act_flat)
    );

    // address, write word, expected readback
    localparam logic [4:0]  T_ADDR [NV] = '{5'd2, 5'd3, 5'd4, 5'd5, 5'd7, 5'd9};
    localparam logic [31:0] T_DATA [NV] = '{32'hDEADBEEF, 32'h1234ABCD, 32'hA5A50F0F,
                                            32'hFFFF8001, 32'h0000C3C3, 32'h000000AB};
    localparam logic [31:0] T_EXP  [NV] = '{32'hDEADBEEF, 32'h0000ABCD, 32'hA5A50F0F,
                                            32'h00008001, 32'h0000C3C3, 32'h00000000};

    function automatic int nbits_of(input logic [4:0] a);
        if (a >= 5'd8) return 8;
        return a[0] ? 16 : 32;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n, input bit lsb,
                              input bit rdchk, input bit wire2, output logic [31:0] r);
        r = '0;
        for (int i = 0; i < n; i++) begin
            int pos;
            pos = lsb ? i : n - 1 - i;
            sclk = 1'b0;
            sdio_in = w[pos];
            half();
            r[pos] = wire2 ? sdio_out : sdo;
            if (rdchk && wire2 && !sdio_oe) line_bad++;
            if (wire2 && sdo) line_bad++;
            if (!wire2 && sdio_oe) line_bad++;
            sclk = 1'b1;
            half();
        end
    endtask

    task automatic xfer(input bit rd, input logic [4:0] a, input logic [31:0] w, input int n,
                        input bit lsb, input bit idle_hi, input bit wire2, output logic [31:0] r);
        logic [31:0] dummy;
        line_bad = 0;
        sclk = idle_hi;
        half();
        cs_n = 1'b0;
        half();
        shift_bits({24'd0, rd, 2'b00, a}, 8, lsb, 1'b0, wire2, dummy);
        shift_bits(w, n, lsb, rd, wire2, r);
        if (!idle_hi) sclk = 1'b0;
        half();
        cs_n = 1'b1;
        half();
        half();
    endtask

    task automatic pulse_upd(input int len);
        @(negedge clk);
        upd = 1'b1;
        repeat (len) @(negedge clk);
        upd = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [31:0] act_word(input int i);
        return act_flat[32*i +: 32];
    endfunction

    initial begin
        repeat (250000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(act_flat == '0, "R1 active regs zero", act_word(0), 32'd0);
        check(!sdo && !sdio_oe, "R1 outputs low", {30'd0, sdo, sdio_oe}, 32'd0);

        // table: write, read back buffer, alternate idle level (R2, R3, R7, R8)
        for (int k = 0; k < NV; k++) begin
            xfer(1'b0, T_ADDR[k], T_DATA[k], nbits_of(T_ADDR[k]), 1'b0, k[0], 1'b0, r);
            xfer(1'b1, T_ADDR[k], 32'd0, nbits_of(T_ADDR[k]), 1'b0, k[0], 1'b0, r);
            check(r == T_EXP[k], "R2 R3 R7 readback", r, T_EXP[k]);
            check(line_bad == 0, "R8 3-wire line use", line_bad, 32'd0);
        end
        check(!sdo && !sdio_oe, "R11 deselected quiet", {30'd0, sdo, sdio_oe}, 32'd0);

        // R4: active registers untouched before update
        check(act_flat == '0, "R4 no update yet", act_word(2), 32'd0);

        // R5: one-cycle pulse ignored, longer pulse copies
        pulse_upd(1);
        check(act_word(2) == 32'd0, "R5 short pulse ignored", act_word(2), 32'd0);
        pulse_upd(3);
        check(act_word(2) == 32'hDEADBEEF, "R4 R5 copy reg2", act_word(2), 32'hDEADBEEF);
        check(act_word(3) == 32'h0000ABCD, "R4 R5 copy reg3", act_word(3), 32'h0000ABCD);
        check(act_word(7) == 32'h0000C3C3, "R5 copy reg7", act_word(7), 32'h0000C3C3);

        // R9: partial word discarded
        xfer(1'b0, 5'd2, 32'h11111111, 20, 1'b0, 1'b0, 1'b0, r);
        xfer(1'b1, 5'd2, 32'd0, 32, 1'b0, 1'b0, 1'b0, r);
        check(r == 32'hDEADBEEF, "R9 partial discarded", r, 32'hDEADBEEF);

        // R9: bits beyond the word ignored (24 bits sent MSB first to 16-bit reg)
        xfer(1'b0, 5'd3, 32'h005AC311, 24, 1'b0, 1'b1, 1'b0, r);
        xfer(1'b1, 5'd3, 32'd0, 16, 1'b0, 1'b1, 1'b0, r);
        check(r == 32'h00005AC3, "R9 trailing bits ignored", r, 32'h00005AC3);

        // R10: abort mid-write, then fresh instruction without raising cs_n
        sclk = 1'b0;
        half();
        cs_n = 1'b0;
        half();
        shift_bits(32'h00000004, 8, 1'b0, 1'b0, 1'b0, r);
        shift_bits(32'hFFFFFFFF, 10, 1'b0, 1'b0, 1'b0, r);
        @(negedge clk);
        io_rst = 1'b1;
        repeat (4) @(negedge clk);
        io_rst = 1'b0;
        half();
        shift_bits(32'h00000004, 8, 1'b0, 1'b0, 1'b0, r);
        shift_bits(32'h600DF00D, 32, 1'b0, 1'b0, 1'b0, r);
        sclk = 1'b0;
        half();
        cs_n = 1'b1;
        half();
        xfer(1'b1, 5'd4, 32'd0, 32, 1'b0, 1'b0, 1'b0, r);
        check(r == 32'h600DF00D, "R10 fresh instruction", r, 32'h600DF00D);
        xfer(1'b1, 5'd2, 32'd0, 32, 1'b0, 1'b0, 1'b0, r);
        check(r == 32'hDEADBEEF, "R10 registers intact", r, 32'hDEADBEEF);
        check(act_word(2) == 32'hDEADBEEF, "R10 active intact", act_word(2), 32'hDEADBEEF);

        // R6: switch to LSB first, write reg5 LSB first, check through active copy
        xfer(1'b0, 5'd0, 32'h00000001, 32, 1'b0, 1'b0, 1'b0, r);
        pulse_upd(3);
        xfer(1'b0, 5'd5, 32'h00001234, 16, 1'b1, 1'b1, 1'b0, r);
        xfer(1'b1, 5'd5, 32'd0, 16, 1'b1, 1'b1, 1'b0, r);
        check(r == 32'h00001234, "R6 LSB readback", r, 32'h00001234);
        pulse_upd(2);
        check(act_word(5) == 32'h00001234, "R6 LSB order in active", act_word(5), 32'h00001234);

        // R8: two-wire read on shared line
        xfer(1'b0, 5'd0, 32'h00000003, 32, 1'b1, 1'b0, 1'b0, r);
        pulse_upd(3);
        xfer(1'b1, 5'd5, 32'd0, 16, 1'b1, 1'b0, 1'b1, r);
        check(r == 32'h00001234, "R8 2-wire data", r, 32'h00001234);
        check(line_bad == 0, "R8 2-wire line use", line_bad, 32'd0);
        check(!sdo && !sdio_oe, "R11 quiet after read", {30'd0, sdo, sdio_oe}, 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule